// File: doc/BRIEF.md
# Multiplexed Bus Address Latch and Chip-Select Decoder

This block sits between a processor that shares its low sixteen address bits with the data lines and the peripherals on that bus. When the address strobe is seen low at a rising clock edge, the block captures the shared lines as the low half of the address. It keeps that value until the next strobe. The eight upper address bits arrive on their own pins and are decoded directly, with no latching. Together with the held low half, they form a 24-bit address. That address is compared against a set of parameterised regions to produce one chip select per device.

A select is raised only while the read or the write strobe is active. It is suppressed whenever the processor status reports an idle bus or a hold request is pending. In both of those states the address pins may be undriven and can float into a matching pattern. When regions overlap, the lowest-numbered region wins, so at most one select is ever active.

Top module: `mux_bus_decoder`

## Requirements
- R1: After reset, `lat_addr` reads 0x0000 and every bit of `cs` is 0.
- R2: When `as_n` is low at a rising clock edge, `lat_addr` takes the value of `ad` from that edge. The new value is visible after the edge.
- R3: While `as_n` is high at a rising edge, `lat_addr` keeps its value, whatever `ad` carries.
- R4: Region i matches when ({`a_hi`,`lat_addr`} AND MASK[i]) equals BASE[i]. With the default parameters, the four regions are as follows. Region 0 has base 0xFFFE00 and mask 0xFFFFC0, which is a 64-byte peripheral window. Region 1 has base 0xFF0000 and mask 0xFF0000. Region 2 has base 0x000000 and mask 0xF00000. Region 3 has base 0x100000 and mask 0xF00000.
- R5: When several regions match, only the lowest-numbered one drives its `cs` bit high. At most one `cs` bit is ever high.
- R6: No `cs` bit is high unless `rd_n` or `wr_n` is low. Both strobes are active low.
- R7: When `st` equals 4'b0000 (bus idle), every `cs` bit is 0, whatever the address and strobes show.
- R8: When `hold_req` is 1, every `cs` bit is 0, whatever the address and strobes show.
- R9: `a_hi` is decoded in the same cycle it is applied, with no latching. The selects follow the inputs combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| ad | input | 16 | Shared low address/data lines |
| a_hi | input | 8 | Upper address bits 23..16 |
| as_n | input | 1 | Address strobe, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| hold_req | input | 1 | Bus hold request, active high |
| st | input | 4 | Processor status code, 0000 means idle |
| lat_addr | output | 16 | Latched low address |
| cs | output | NSEL | One chip select per region, active high |

## Verification
Two functions can fall in the same cycle: a new address strobe, and a read or write strobe that hits a region. During that cycle the decode must still use the previously held low half; the fresh value takes effect only after the edge. The random stimulus asserts the address strobe and a data strobe together often, and it biases the upper bits toward the region bases. Each cycle's selects are compared before the edge against a bench model that updates its own latched copy only at the edge. The same comparisons cover idle status and hold arriving on a matching cycle, where the selects must drop.

// File: rtl/mux_bus_decoder.sv
module mux_bus_decoder #(
  parameter int NSEL = 4,
  parameter int AW   = 24,
  parameter int LW   = 16,
  parameter logic [NSEL*AW-1:0] BASES = {24'h100000, 24'h000000, 24'hFF0000, 24'hFFFE00},
  parameter logic [NSEL*AW-1:0] MASKS = {24'hF00000, 24'hF00000, 24'hFF0000, 24'hFFFFC0}
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [LW-1:0]   ad,
  input  logic [AW-LW-1:0] a_hi,
  input  logic            as_n,
  input  logic            rd_n,
  input  logic            wr_n,
  input  logic            hold_req,
  input  logic [3:0]      st,
  output logic [LW-1:0]   lat_addr,
  output logic [NSEL-1:0] cs
);

  localparam logic [3:0] ST_IDLE = 4'b0000;

  logic [AW-1:0]   full_addr;
  logic [NSEL-1:0] hit;
  logic [NSEL-1:0] pick;
  logic            bus_ok;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)      lat_addr <= '0;
    else if (!as_n)  lat_addr <= ad;

  assign full_addr = {a_hi, lat_addr};
  assign bus_ok    = (!rd_n || !wr_n) && (st != ST_IDLE) && !hold_req;

  for (genvar i = 0; i < NSEL; i++) begin : g_region
    assign hit[i] = (full_addr & MASKS[i*AW +: AW]) == BASES[i*AW +: AW];
  end

  always_comb begin
    pick = '0;
    for (int i = 0; i < NSEL; i++)
      if (hit[i] && pick == '0) pick[i] = 1'b1;
  end

  assign cs = bus_ok ? pick : '0;

  p_latch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !as_n |=> lat_addr == $past(ad));
  p_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |=> $stable(lat_addr));
  p_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cs));
  p_strobe_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_n && wr_n) |-> cs == '0);
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |-> cs == '0);
  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    hold_req |-> cs == '0);

endmodule

// File: tb/mux_bus_decoder_test.sv
module mux_bus_decoder_test;
  logic clk = 0, rst_n = 0;
  logic [15:0] ad = 0;
  logic [7:0] a_hi = 0;
  logic as_n = 1, rd_n = 1, wr_n = 1, hold_req = 0;
  logic [3:0] st = 4'h1;
  logic [15:0] lat_addr;
  logic [3:0] cs;
  logic [15:0] mlat = 0;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  mux_bus_decoder uut (.clk(clk), .rst_n(rst_n), .ad(ad), .a_hi(a_hi), .as_n(as_n),
    .rd_n(rd_n), .wr_n(wr_n), .hold_req(hold_req), .st(st), .lat_addr(lat_addr), .cs(cs));

  function automatic logic [3:0] exp_cs(logic [7:0] h, logic [15:0] l, logic r, logic w,
                                        logic [3:0] s, logic hd);
    logic [23:0] a = {h, l};
    logic [3:0] m;
    m[0] = (a & 24'hFFFFC0) == 24'hFFFE00;
    m[1] = (a & 24'hFF0000) == 24'hFF0000;
    m[2] = (a & 24'hF00000) == 24'h000000;
    m[3] = (a & 24'hF00000) == 24'h100000;
    if ((r && w) || s == 4'b0000 || hd) return 4'b0000;
    for (int i = 0; i < 4; i++) if (m[i]) return 4'b0001 << i;
    return 4'b0000;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive at negedge, compare before posedge, update model at posedge
  task automatic step(string req, logic [15:0] d, logic [7:0] h, logic a, logic r, logic w,
                      logic [3:0] s, logic hd);
    @(negedge clk);
    chk("R2/R3 lat_addr", {16'h0, lat_addr}, {16'h0, mlat});
    ad = d; a_hi = h; as_n = a; rd_n = r; wr_n = w; st = s; hold_req = hd;
    #1;
    chk(req, {28'h0, cs}, {28'h0, exp_cs(h, mlat, r, w, s, hd)});
    @(posedge clk);
    if (!a) mlat = d;
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed1234));
    #1;
    chk("R1 lat_addr reset", {16'h0, lat_addr}, 0);
    chk("R1 cs reset", {28'h0, cs}, 0);
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    // R2 latch the peripheral offset, R4 region 0 and R5 priority over region 1
    step("R2 strobe", 16'hFE10, 8'hFF, 0, 1, 1, 4'h1, 0);
    step("R4/R5 region0 read", 16'h0000, 8'hFF, 1, 0, 1, 4'h1, 0);
    // R3 ad changes while as_n high
    step("R3 hold value", 16'h1234, 8'hFF, 1, 1, 0, 4'h1, 0);
    // R6 no strobe
    step("R6 no strobe", 16'h0000, 8'hFF, 1, 1, 1, 4'h1, 0);
    // R7 idle with match
    step("R7 idle", 16'h0000, 8'hFF, 1, 0, 1, 4'h0, 0);
    // R8 hold with match
    step("R8 hold", 16'h0000, 8'hFF, 1, 0, 0, 4'h2, 1);
    // R9 upper bits change live: region 3 then region 2 without a new strobe
    step("R9 region3 live", 16'h0000, 8'h12, 1, 0, 1, 4'h3, 0);
    step("R9 region2 live", 16'h0000, 8'h05, 1, 1, 0, 4'h3, 0);
    // R4 boundary: just outside the 64-byte window -> region 1
    step("R2 strobe edge", 16'hFE40, 8'hFF, 0, 1, 1, 4'h1, 0);
    step("R4 window edge", 16'h0000, 8'hFF, 1, 0, 1, 4'h1, 0);
    // strobe and read together: decode uses old latched value
    step("R2/R5 same cycle", 16'hFE3F, 8'hFF, 0, 0, 1, 4'h1, 0);
    step("R4 window top", 16'h0000, 8'hFF, 1, 0, 1, 4'h1, 0);
    step("R4 no region", 16'h0000, 8'h80, 1, 0, 1, 4'h1, 0);
    for (int n = 0; n < 3000; n++) begin
      logic [7:0] h;
      logic [15:0] d;
      case ($urandom % 6)
        0: h = 8'hFF; 1: h = 8'h00; 2: h = 8'h0F; 3: h = 8'h10; 4: h = 8'h1F;
        default: h = 8'($urandom);
      endcase
      d = ($urandom % 3 == 0) ? (16'hFE00 | 16'($urandom % 128)) : 16'($urandom);
      step("R4/R5/R6/R7/R8 random", d, h, 1'($urandom % 2), 1'($urandom % 2),
           1'($urandom % 2), ($urandom % 4 == 0) ? 4'h0 : 4'($urandom),
           ($urandom % 5 == 0));
    end
    @(negedge clk);
    chk("R2/R3 final lat_addr", {16'h0, lat_addr}, {16'h0, mlat});
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule